// File: doc/BRIEF.md
# Store-to-Load Address Conflict Checker

This block decides, every cycle, whether a pending load may go ahead with its memory access. It keeps one tracking entry per reorder-buffer slot. An entry is opened when a store is allocated into that slot. It receives the store's effective address once the address is computed. It is released when the store commits and writes memory. Because stores write memory only at the head of the reorder buffer, the block does not check write-after-write or write-after-read hazards through memory. It guards only read-after-write.

A load request presents the load's reorder-buffer slot and its address. The block compares the address against every tracked store that is older than the load. Age is measured circularly from the current reorder-buffer head. The load is refused if any such store has the same address, or if any such store has an address that is not yet known. A second request port lets a load ask whether it may produce its own effective address. That is allowed only when every older tracked store already has its address, which keeps load address computation in program order with respect to stores. Both answers are combinational from the current table and the request. A flush empties the table in one cycle. The depth must be a power of two.

Top module: `st_ld_conflict_chk`

## Requirements
- R1: After reset no store is tracked, so a load request is granted and an address request is allowed whatever slot or address is presented.
- R2: A load is refused while a tracked store that is older than it holds an address equal to the load's address.
- R3: A tracked older store whose known address differs from the load's address does not block the load.
- R4: A tracked older store whose address is still unknown blocks the load, whatever the load's address.
- R5: Age is the slot index minus the head index, modulo the depth. Only stores with a smaller age than the load take part, so stores at or after the load's age never block it, including when the head has wrapped past the store's slot.
- R6: In the cycle after a store's commit is signalled, that store no longer blocks any load.
- R7: A flush removes every tracked store in that cycle and takes priority over an allocation in the same cycle. From the next cycle all requests are granted.
- R8: An address request is refused while any older tracked store has an unknown address. Older stores with known addresses, matching or not, do not refuse it.
- R9: With a request input low, the matching answer output (grant or address-allowed) is low.
- R10: An address capture aimed at a slot with no tracked store is ignored. A store later allocated into that slot starts with an unknown address.
- R11: When a commit and a new allocation name the same slot in the same cycle, the allocation wins. The slot stays tracked, with an unknown address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Drop all tracked stores |
| head_i | input | IDX_W | Reorder-buffer head slot (oldest) |
| st_alloc_i | input | 1 | Open an entry for a newly issued store |
| st_alloc_idx_i | input | IDX_W | Slot of the allocated store |
| st_addr_vld_i | input | 1 | Store effective address is available |
| st_addr_idx_i | input | IDX_W | Slot of the store whose address arrives |
| st_addr_i | input | ADDR_W | Store effective address |
| st_commit_i | input | 1 | Store has written memory; release its entry |
| st_commit_idx_i | input | IDX_W | Slot of the committing store |
| ld_req_i | input | 1 | Load asks to access memory |
| ld_idx_i | input | IDX_W | Slot of the requesting load |
| ld_addr_i | input | ADDR_W | Address of the requesting load |
| ld_grant_o | output | 1 | Load may access memory now |
| ea_req_i | input | 1 | Load asks to compute its effective address |
| ea_idx_i | input | IDX_W | Slot of that load |
| ea_ok_o | output | 1 | Load may compute its effective address |

## Verification
The hardest situation to reach is a store whose slot index is numerically below the load's slot while the store is younger, because the head has wrapped. The stimulus keeps one store with a known address in the table. It then moves the head so that the same store falls first before and then after the load in age order, and checks that the grant flips. The stimulus also reaches the same-cycle collisions: commit with reallocation of one slot, flush with allocation, and an address capture into an empty slot followed by a later allocation.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned SC_DEPTH  = 8;
  localparam int unsigned SC_ADDR_W = 16;

  // per-entry reason a load is held
  typedef enum logic [1:0] {
    BLK_NONE    = 2'd0,
    BLK_UNKNOWN = 2'd1,
    BLK_MATCH   = 2'd2
  } blk_e;
endpackage

// File: rtl/sc_age_rel.sv
module sc_age_rel #(
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] head_i,
  output logic [IDX_W-1:0] rel_o
);
  // modulo wrap relies on power-of-two depth
  assign rel_o = idx_i - head_i;
endmodule

// File: rtl/sc_store_table.sv
module sc_store_table #(
  parameter int unsigned DEPTH  = sc_pkg::SC_DEPTH,
  parameter int unsigned ADDR_W = sc_pkg::SC_ADDR_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic                          alloc_i,
  input  logic [IDX_W-1:0]              alloc_idx_i,
  input  logic                          cap_i,
  input  logic [IDX_W-1:0]              cap_idx_i,
  input  logic [ADDR_W-1:0]             cap_addr_i,
  input  logic                          commit_i,
  input  logic [IDX_W-1:0]              commit_idx_i,
  output logic [DEPTH-1:0]              vld_o,
  output logic [DEPTH-1:0]              known_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]  addr_o
);
  logic [DEPTH-1:0]             vld_q, known_q;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic alloc_hit, commit_hit, cap_hit;
    assign alloc_hit  = alloc_i  && (alloc_idx_i  == IDX_W'(g));
    assign commit_hit = commit_i && (commit_idx_i == IDX_W'(g));
    assign cap_hit    = cap_i    && (cap_idx_i    == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]   <= 1'b0;
        known_q[g] <= 1'b0;
        addr_q[g]  <= '0;
      end else if (flush_i) begin
        vld_q[g]   <= 1'b0;
        known_q[g] <= 1'b0;
      end else if (alloc_hit) begin
        vld_q[g]   <= 1'b1;
        known_q[g] <= 1'b0;
      end else if (commit_hit) begin
        vld_q[g]   <= 1'b0;
        known_q[g] <= 1'b0;
      end else if (cap_hit && vld_q[g]) begin
        known_q[g] <= 1'b1;
        addr_q[g]  <= cap_addr_i;
      end
    end

    // R6
    commit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_hit && !alloc_hit) |=> !vld_q[g]);

    // R7
    flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (!vld_q[g] && !known_q[g]));

    // R11
    alloc_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alloc_hit && !flush_i) |=> (vld_q[g] && !known_q[g]));

    // R10
    cap_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_hit && !vld_q[g] && !alloc_hit) |=> !known_q[g]);
  end

  assign vld_o   = vld_q;
  assign known_o = known_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/sc_conflict_scan.sv
module sc_conflict_scan #(
  parameter int unsigned DEPTH  = sc_pkg::SC_DEPTH,
  parameter int unsigned ADDR_W = sc_pkg::SC_ADDR_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]              head_i,
  input  logic [IDX_W-1:0]              ld_idx_i,
  input  logic [ADDR_W-1:0]             ld_addr_i,
  input  logic [IDX_W-1:0]              ea_idx_i,
  input  logic [DEPTH-1:0]              vld_i,
  input  logic [DEPTH-1:0]              known_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  addr_i,
  output sc_pkg::blk_e [DEPTH-1:0]      ld_blk_o,
  output logic [DEPTH-1:0]              ea_blk_o
);
  logic [IDX_W-1:0] ld_rel, ea_rel;

  sc_age_rel #(.IDX_W(IDX_W)) u_ld_age (.idx_i(ld_idx_i), .head_i(head_i), .rel_o(ld_rel));
  sc_age_rel #(.IDX_W(IDX_W)) u_ea_age (.idx_i(ea_idx_i), .head_i(head_i), .rel_o(ea_rel));

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [IDX_W-1:0] st_rel;
    logic             older_ld, older_ea;

    sc_age_rel #(.IDX_W(IDX_W)) u_st_age (
      .idx_i(IDX_W'(g)), .head_i(head_i), .rel_o(st_rel));

    assign older_ld = vld_i[g] && (st_rel < ld_rel);
    assign older_ea = vld_i[g] && (st_rel < ea_rel);

    always_comb begin
      ld_blk_o[g] = sc_pkg::BLK_NONE;
      if (older_ld) begin
        if (!known_i[g])                  ld_blk_o[g] = sc_pkg::BLK_UNKNOWN;
        else if (addr_i[g] == ld_addr_i)  ld_blk_o[g] = sc_pkg::BLK_MATCH;
      end
    end

    assign ea_blk_o[g] = older_ea && !known_i[g];
  end
endmodule

// File: rtl/st_ld_conflict_chk.sv
module st_ld_conflict_chk #(
  parameter int unsigned DEPTH  = sc_pkg::SC_DEPTH,
  parameter int unsigned ADDR_W = sc_pkg::SC_ADDR_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  head_i,
  input  logic              st_alloc_i,
  input  logic [IDX_W-1:0]  st_alloc_idx_i,
  input  logic              st_addr_vld_i,
  input  logic [IDX_W-1:0]  st_addr_idx_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              st_commit_i,
  input  logic [IDX_W-1:0]  st_commit_idx_i,
  input  logic              ld_req_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              ld_grant_o,
  input  logic              ea_req_i,
  input  logic [IDX_W-1:0]  ea_idx_i,
  output logic              ea_ok_o
);
  logic [DEPTH-1:0]             vld, known;
  logic [DEPTH-1:0][ADDR_W-1:0] addr;
  sc_pkg::blk_e [DEPTH-1:0]     ld_blk;
  logic [DEPTH-1:0]             ea_blk;
  logic                         ld_held;

  sc_store_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .alloc_i     (st_alloc_i),
    .alloc_idx_i (st_alloc_idx_i),
    .cap_i       (st_addr_vld_i),
    .cap_idx_i   (st_addr_idx_i),
    .cap_addr_i  (st_addr_i),
    .commit_i    (st_commit_i),
    .commit_idx_i(st_commit_idx_i),
    .vld_o       (vld),
    .known_o     (known),
    .addr_o      (addr)
  );

  sc_conflict_scan #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_scan (
    .head_i   (head_i),
    .ld_idx_i (ld_idx_i),
    .ld_addr_i(ld_addr_i),
    .ea_idx_i (ea_idx_i),
    .vld_i    (vld),
    .known_i  (known),
    .addr_i   (addr),
    .ld_blk_o (ld_blk),
    .ea_blk_o (ea_blk)
  );

  always_comb begin
    ld_held = 1'b0;
    for (int i = 0; i < int'(DEPTH); i++)
      if (ld_blk[i] != sc_pkg::BLK_NONE) ld_held = 1'b1;
  end

  assign ld_grant_o = ld_req_i && !ld_held;
  assign ea_ok_o    = ea_req_i && !(|ea_blk);

  // R8
  grant_implies_ea_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_grant_o && ea_req_i && (ea_idx_i == ld_idx_i)) |-> ea_ok_o);

  // R7
  grant_after_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && ld_req_i) |=> (!ld_req_i || ld_grant_o));
endmodule

// File: tb/st_ld_conflict_chk_test.sv
`timescale 1ns/1ps
module st_ld_conflict_chk_test;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [IW-1:0] head = '0;
  logic st_alloc = 1'b0, st_cap = 1'b0, st_com = 1'b0;
  logic [IW-1:0] alloc_idx = '0, cap_idx = '0, com_idx = '0;
  logic [AW-1:0] cap_addr = '0;
  logic ld_req = 1'b0, ea_req = 1'b0;
  logic [IW-1:0] ld_idx = '0, ea_idx = '0;
  logic [AW-1:0] ld_addr = '0;
  logic ld_grant, ea_ok;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic  g;
    logic  e;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  st_ld_conflict_chk #(.DEPTH(DEPTH), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .head_i(head),
    .st_alloc_i(st_alloc), .st_alloc_idx_i(alloc_idx),
    .st_addr_vld_i(st_cap), .st_addr_idx_i(cap_idx), .st_addr_i(cap_addr),
    .st_commit_i(st_com), .st_commit_idx_i(com_idx),
    .ld_req_i(ld_req), .ld_idx_i(ld_idx), .ld_addr_i(ld_addr),
    .ld_grant_o(ld_grant),
    .ea_req_i(ea_req), .ea_idx_i(ea_idx), .ea_ok_o(ea_ok)
  );

  // monitor: compares the item pushed in this cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        total++;
        if (ld_grant !== x.g || ea_ok !== x.e) begin
          bad++;
          $display("FAIL %s: grant=%b ea_ok=%b expected grant=%b ea_ok=%b",
                   x.tag, ld_grant, ea_ok, x.g, x.e);
        end
      end
    end
  end

  task automatic step(input logic al, input int ai, input logic cp, input int ci,
                      input int ca, input logic cm, input int mi, input logic fl);
    @(negedge clk);
    st_alloc = al; alloc_idx = IW'(ai);
    st_cap = cp;   cap_idx = IW'(ci); cap_addr = AW'(ca);
    st_com = cm;   com_idx = IW'(mi);
    flush = fl;
    @(negedge clk);
    st_alloc = 0; st_cap = 0; st_com = 0; flush = 0;
  endtask

  task automatic probe(input int h, input logic lr, input int li, input int la,
                       input logic er, input int ei, input logic eg, input logic ee,
                       input string tag);
    exp_t x;
    @(negedge clk);
    #1;
    head = IW'(h); ld_req = lr; ld_idx = IW'(li); ld_addr = AW'(la);
    ea_req = er; ea_idx = IW'(ei);
    x.g = eg; x.e = ee; x.tag = tag;
    sb.push_back(x);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    probe(0, 1, 3, 'h10, 1, 3, 1, 1, "R1 empty table grants");
    step(1, 1, 0, 0, 0, 0, 0, 0);                          // store in slot 1, address unknown
    probe(0, 1, 3, 'h55, 1, 3, 0, 0, "R4 unknown older store blocks; R8 ea refused");
    probe(0, 1, 0, 'h55, 1, 0, 1, 1, "R5 younger store ignored");
    step(0, 0, 1, 1, 'h40, 0, 0, 0);                       // slot 1 address 0x40
    probe(0, 1, 3, 'h40, 1, 3, 0, 1, "R2 matching older store blocks; R8 known ok");
    probe(0, 1, 3, 'h44, 1, 3, 1, 1, "R3 different address passes");
    probe(6, 1, 7, 'h40, 1, 7, 1, 1, "R5 wrapped head: store younger");
    probe(6, 1, 2, 'h40, 1, 2, 0, 1, "R5 wrapped head: store older blocks");
    step(0, 0, 0, 0, 0, 1, 1, 0);                          // commit slot 1
    probe(6, 1, 2, 'h40, 1, 2, 1, 1, "R6 committed store released");
    probe(0, 0, 3, 'h40, 0, 3, 0, 0, "R9 no request no answer");

    step(0, 0, 1, 4, 'h40, 0, 0, 0);                       // capture into empty slot 4
    probe(0, 1, 5, 'h40, 1, 5, 1, 1, "R10 capture into empty slot ignored");
    step(1, 4, 0, 0, 0, 0, 0, 0);
    probe(0, 1, 5, 'h99, 1, 5, 0, 0, "R10 new alloc starts unknown");
    step(0, 0, 1, 4, 'h99, 0, 0, 0);
    probe(0, 1, 5, 'h99, 1, 5, 0, 1, "R2 captured address matches");
    probe(0, 1, 5, 'h98, 1, 5, 1, 1, "R3 captured address differs");
    step(0, 0, 0, 0, 0, 1, 4, 0);

    step(1, 2, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 2, 'h80, 0, 0, 0);
    probe(0, 1, 5, 'h81, 1, 5, 1, 1, "R3 slot 2 known, no match");
    step(1, 2, 0, 0, 0, 1, 2, 0);                          // commit and realloc slot 2
    probe(0, 1, 5, 'h81, 1, 5, 0, 0, "R11 realloc wins over commit");

    step(1, 3, 0, 0, 0, 0, 0, 0);
    step(1, 6, 0, 0, 0, 0, 0, 1);                          // flush with alloc
    probe(0, 1, 7, 'h80, 1, 7, 1, 1, "R7 flush clears all and beats alloc");

    @(negedge clk);
    ld_req = 0; ea_req = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule